// File: doc/BRIEF.md
# Ten-Lane Uniform Coefficient Sampler

The block turns a stream of 1344-bit pseudorandom blocks into coefficients drawn uniformly from 0 to 3328. Each block is split into 112 twelve-bit candidates and appended to a shift buffer. Every cycle, up to ten candidates leave the buffer head and pass through ten parallel compare lanes. A lane keeps its candidate only when the value is below the modulus.

The kept candidates are packed in lane order behind the entries left over from the previous cycle, in a 14-entry queue. When the queue holds at least four entries, the oldest four are presented together as one output beat. The beat comes with a valid flag, and a multiplier downstream advances only on that flag. A full flag halts buffer reads while more than four entries remain queued, so the next ten candidates always fit. A request flag asks the block producer for new data once fewer than eight unread candidates remain. A block offered at that point is appended behind the unread candidates, so no candidate is lost.

Top module: `rej_sampler_lanes`

## Requirements
- R1: Candidate k of a loaded block (k = 0 to 111) is `blk_data[12k+11:12k]`. Candidates enter the stream in ascending k, and each block follows the unread candidates of earlier blocks.
- R2: A candidate is kept exactly when its value is below 3329. So 3328 and 0 are kept, and 3329 and 4095 are dropped.
- R3: The output stream holds the kept candidates in stream order, with nothing lost or repeated. Within a beat, `coef_data[12j+11:12j]` (j = 0 to 3) is the j-th oldest of the four.
- R4: `coef_valid` is high only on a cycle that carries four kept candidates. While fewer than four are available, it stays low and no partial beat is issued.
- R5: A cycle that reads the buffer removes min(10, unread) candidates from its head.
- R6: `fifo_full` is high exactly when more than four entries remain queued after the previous cycle's output. While it is high, no candidate is read from the buffer.
- R7: The queue never holds more than 14 entries.
- R8: `blk_req` is high exactly when fewer than 8 candidates remain unread. A load raised while it is high is accepted.
- R9: A load raised while `blk_req` is low is ignored, and its candidates never appear at the output.
- R10: After reset, `coef_valid` and `fifo_full` are low, `blk_req` is high, and the buffer and queue are empty.
- R11: An all-kept block loaded into an empty sampler gives 28 back-to-back valid beats. The first beat is visible one clock edge after the loading edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_load | input | 1 | Offer `blk_data` as a new block |
| blk_data | input | 1344 | 112 packed 12-bit candidates, lowest first |
| blk_req | output | 1 | Fewer than 8 unread candidates; a load is accepted |
| fifo_full | output | 1 | Buffer reads halted this cycle |
| coef_valid | output | 1 | `coef_data` holds four kept coefficients |
| coef_data | output | 48 | Four coefficients, oldest in the low bits |

## Verification
Two events can land on the same clock edge: a new block is appended while the buffer head shifts out ten candidates, and a full stall holds reads while the queue still emits a beat. The table stream offers each block at the first cycle `blk_req` rises. That cycle is normally also a read cycle, so the append position must take account of the shift made on the same edge. Any error there shows up as a misordered or missing coefficient against the bench's software filter. The all-kept directed run alternates stall cycles with read cycles. On every cycle it checks the full flag, the request flag and the valid flag against a cycle model of the occupancy.

// File: rtl/rej_sampler_lanes.sv
module rej_sampler_lanes #(
  parameter int CW     = 12,
  parameter int NCAND  = 112,
  parameter int LANES  = 10,
  parameter int NOUT   = 4,
  parameter int Q      = 3329,
  parameter int REQ_TH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  blk_load,
  input  logic [CW*NCAND-1:0]   blk_data,
  output logic                  blk_req,
  output logic                  fifo_full,
  output logic                  coef_valid,
  output logic [CW*NOUT-1:0]    coef_data
);

  localparam int SLOTS = NCAND + REQ_TH;
  localparam int DEPTH = LANES + NOUT;
  localparam int BW    = CW * SLOTS;
  localparam int PADW  = BW - CW * NCAND;
  localparam int SCW   = $clog2(SLOTS + 1);
  localparam int OCW   = $clog2(DEPTH + 1);

  logic [BW-1:0]    buf_q, buf_d;
  logic [SCW-1:0]   cnt_q, cnt_d, cnt_r, n_take;
  logic [OCW-1:0]   occ_q, occ_d, tot;
  logic [CW-1:0]    fifo_q [DEPTH];
  logic [CW-1:0]    fifo_d [DEPTH];
  logic [CW-1:0]    merged [DEPTH];
  logic [LANES-1:0] lane_keep;
  logic             take, load_ok, pop;

  assign blk_req   = cnt_q < SCW'(REQ_TH);
  assign fifo_full = occ_q > OCW'(NOUT);
  assign take      = !fifo_full && (cnt_q != '0);
  assign load_ok   = blk_load && blk_req;
  assign n_take    = !take ? '0 : (cnt_q > SCW'(LANES)) ? SCW'(LANES) : cnt_q;
  assign cnt_r     = cnt_q - n_take;
  assign cnt_d     = cnt_r + (load_ok ? SCW'(NCAND) : '0);

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign lane_keep[gi] = take && (cnt_q > SCW'(gi)) &&
                             (buf_q[gi*CW +: CW] < CW'(Q));
    end
  endgenerate

  always_comb begin
    buf_d = (take ? (buf_q >> (LANES * CW)) : buf_q) |
            (load_ok ? ({{PADW{1'b0}}, blk_data} << (cnt_r * CW)) : '0);
  end

  always_comb begin
    tot = occ_q;
    for (int k = 0; k < DEPTH; k++)
      merged[k] = (OCW'(k) < occ_q) ? fifo_q[k] : '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_keep[i] && tot < OCW'(DEPTH)) begin
        merged[tot] = buf_q[i*CW +: CW];
        tot = tot + OCW'(1);
      end
    end
  end

  assign pop   = tot >= OCW'(NOUT);
  assign occ_d = pop ? tot - OCW'(NOUT) : tot;

  always_comb begin
    for (int k = 0; k < DEPTH - NOUT; k++)
      fifo_d[k] = pop ? merged[k + NOUT] : merged[k];
    for (int k = DEPTH - NOUT; k < DEPTH; k++)
      fifo_d[k] = pop ? '0 : merged[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q      <= '0;
      cnt_q      <= '0;
      occ_q      <= '0;
      coef_valid <= 1'b0;
      coef_data  <= '0;
      for (int k = 0; k < DEPTH; k++) fifo_q[k] <= '0;
    end else begin
      buf_q      <= buf_d;
      cnt_q      <= cnt_d;
      occ_q      <= occ_d;
      coef_valid <= pop;
      for (int k = 0; k < DEPTH; k++) fifo_q[k] <= fifo_d[k];
      if (pop)
        for (int j = 0; j < NOUT; j++) coef_data[j*CW +: CW] <= merged[j];
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCW'(DEPTH));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !blk_load) |=> $stable(cnt_q));

  assert_ignore_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_load && !blk_req) |=> (cnt_q <= $past(cnt_q)));

  assert_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_load && blk_req) |=> !blk_req);

  generate
    for (gi = 0; gi < NOUT; gi++) begin : g_rng
      assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid |-> (coef_data[gi*CW +: CW] < CW'(Q)));
    end
  endgenerate

endmodule

// File: tb/rej_sampler_lanes_tb.sv
module rej_sampler_lanes_tb;
  localparam int CLK_P = 10;
  localparam int CW = 12;
  localparam int NC = 112;
  localparam int Q  = 3329;
  localparam int NV = 8;
  localparam logic [1:0]  VMODE [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd3, 2'd0};
  localparam logic [31:0] VSEED [NV] = '{32'h1234_5678, 32'h0BAD_F00D, 32'h0000_0777,
                                         32'hCAFE_0001, 32'h5A5A_1111, 32'h9E37_79B9,
                                         32'h0F0F_2222, 32'h7777_AAAA};

  logic clk = 1'b0, rst_n = 1'b0, blk_load = 1'b0;
  logic [CW*NC-1:0] blk_data = '0;
  logic blk_req, fifo_full, coef_valid;
  logic [CW*4-1:0] coef_data;
  int checks = 0, fails = 0, cyc = 0;
  logic [CW-1:0] expq [$];

  rej_sampler_lanes u_dut (.clk(clk), .rst_n(rst_n), .blk_load(blk_load),
    .blk_data(blk_data), .blk_req(blk_req), .fifo_full(fifo_full),
    .coef_valid(coef_valid), .coef_data(coef_data));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  function automatic logic [CW*NC-1:0] make_blk(input logic [1:0] mode, input logic [31:0] seed);
    logic [CW*NC-1:0] b = '0;
    logic [31:0] s = seed;
    logic [CW-1:0] c;
    for (int k = 0; k < NC; k++) begin
      s = xs(s);
      case (mode)
        2'd0: c = s[CW-1:0];
        2'd1: c = CW'(s % Q);
        2'd2: c = CW'(Q + s % (4096 - Q));
        default: case (k % 4)
          0: c = 12'd3328;
          1: c = 12'd3329;
          2: c = 12'd0;
          default: c = 12'd4095;
        endcase
      endcase
      b[k*CW +: CW] = c;
    end
    return b;
  endfunction

  task automatic push_exp(input logic [CW*NC-1:0] b);
    for (int k = 0; k < NC; k++)
      if (b[k*CW +: CW] < Q) expq.push_back(b[k*CW +: CW]);
  endtask

  // R1 R3 R4: output stream against software filter of loaded blocks
  always @(negedge clk) begin
    if (rst_n && coef_valid) begin
      if (expq.size() < 4) begin
        check(1'b0, "R4 beat without four kept", expq.size(), 4);
      end else begin
        logic ok = 1'b1;
        logic [CW*4-1:0] e;
        for (int j = 0; j < 4; j++) begin
          e[j*CW +: CW] = expq.pop_front();
          if (e[j*CW +: CW] != coef_data[j*CW +: CW]) ok = 1'b0;
        end
        check(ok, "R1/R3 beat content", coef_data, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic do_reset;
    rst_n = 1'b0; blk_load = 1'b0;
    repeat (3) @(negedge clk);
    expq.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_req;
    int n = 0;
    while (!blk_req && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic load_blk(input logic [CW*NC-1:0] b);
    blk_data = b; blk_load = 1'b1;
    push_exp(b);
    @(negedge clk);
    blk_load = 1'b0;
  endtask

  initial begin
    do_reset();
    // R10 reset state
    check(coef_valid == 1'b0, "R10 valid", coef_valid, 0);
    check(fifo_full == 1'b0, "R10 full", fifo_full, 0);
    check(blk_req == 1'b1, "R10 req", blk_req, 1);

    // table walk: continuous stream, R1 R2 R3 R5 R8
    for (int v = 0; v < NV; v++) begin
      wait_req();
      load_blk(make_blk(VMODE[v], VSEED[v]));
      if (VMODE[v] == 2'd3) begin
        // R9: load right after an accepted one must be ignored
        check(blk_req == 1'b0, "R9 req low after load", blk_req, 0);
        blk_data = make_blk(2'd1, 32'hDEAD_0042);
        blk_load = 1'b1;
        @(negedge clk);
        blk_load = 1'b0;
      end
    end
    repeat (80) @(negedge clk);
    check(expq.size() < 4, "R3 stream drained", expq.size(), 0);

    // R11 R6 R8 R5: all-kept block into empty sampler, cycle model
    do_reset();
    begin
      int cnt = 0, occ = 0, beats = 0, run = 0;
      logic ev = 1'b0;
      load_blk(make_blk(2'd1, 32'h0246_8ACE));
      cnt = NC;
      for (int t = 0; t < 34; t++) begin
        int n, tt;
        logic tk;
        check(fifo_full == (occ > 4), "R6 full flag", fifo_full, occ > 4);
        check(blk_req == (cnt < 8), "R8 req flag", blk_req, cnt < 8);
        check(coef_valid == ev, "R11 valid timing", coef_valid, ev);
        if (coef_valid) beats++;
        tk = !(occ > 4) && cnt > 0;
        n = tk ? ((cnt > 10) ? 10 : cnt) : 0;
        tt = occ + n;
        ev = tt >= 4;
        occ = ev ? tt - 4 : tt;
        cnt -= n;
        @(negedge clk);
      end
      check(beats == 28, "R11 beat count", beats, 28);
      run = expq.size();
      check(run == 0, "R7 nothing lost", run, 0);
    end

    // R2 R4: three kept at the threshold, no beat until a fourth arrives
    do_reset();
    begin
      logic [CW*NC-1:0] b = make_blk(2'd2, 32'h1357_9BDF);
      logic seen = 1'b0;
      b[0 +: CW] = 12'd3328; b[CW +: CW] = 12'd3329;
      b[2*CW +: CW] = 12'd0; b[3*CW +: CW] = 12'd4095;
      b[4*CW +: CW] = 12'd1;
      load_blk(b);
      for (int t = 0; t < 30; t++) begin
        if (coef_valid) seen = 1'b1;
        @(negedge clk);
      end
      check(!seen, "R4 no partial beat", seen, 0);
      wait_req();
      load_blk(make_blk(2'd1, 32'h0000_0005));
      repeat (40) @(negedge clk);
      check(expq.size() < 4, "R2 threshold values streamed", expq.size(), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule